// File: doc/BRIEF.md
# Five-Stage Sequential Processor Core

This block is a small processor core that runs one instruction at a time. Each instruction moves through five steps, one per clock: fetch, decode, execute, memory access and write-back. The next instruction is fetched only after the current one has finished. The core holds a program counter, an instruction register and eight general registers of 32 bits, and it has an adder as its only ALU. One memory port serves both instruction fetches and data accesses.

The core supports five kinds of instruction: load from an absolute address, register-plus-register add, register-plus-immediate add, store to an absolute address, and halt. After reset the core fetches from byte address 16, and it advances by 4 bytes per instruction. A halt instruction freezes the core so that the environment can tell when the program has ended. A retired-instruction count and a cycle count are exported so that cycles per instruction can be measured.

Memory is byte addressed, and each slot holds one 32-bit word. The memory read is combinational: `mem_rdata` must return the word at `mem_addr` within the same cycle. A write takes effect at the clock edge that ends the cycle in which `mem_we` is high.

Top module: `seq5_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `mem_addr` is 16, `mem_we` is 0, `halted` is 0, and both counters are 0.
- R2: Cycle 0 is the cycle right after reset. Instruction k is fetched in cycle 5k from byte address 16+4k, so every instruction other than halt takes exactly five cycles.
- R3: The instruction word is encoded as follows:
  - bits [31:28] hold the opcode;
  - bits [27:25] hold the destination register;
  - bits [24:22] hold source register A;
  - bits [21:19] hold source register B;
  - bits [18:0] hold the immediate.
  
  Opcode 1 is load: the destination register receives the memory word at byte address imm.
- R4: Opcode 2 writes A+B, modulo 2^32, into the destination register. The destination register may also be a source register: the sources are read before the write.
- R5: Opcode 3 writes A plus the zero-extended immediate, modulo 2^32, into the destination register.
- R6: Opcode 4 drives `mem_addr`=imm, `mem_wdata`=A and `mem_we`=1 for exactly one cycle, the fourth cycle of the instruction (cycle 5k+3). `mem_we` is low in every other cycle.
- R7: Any opcode other than 1, 2, 3, 4 and 15 changes no register and no memory word, but it still takes five cycles.
- R8: Opcode 15 (halt) raises `halted` after its decode cycle. From then on, `halted` stays high, both counters are frozen, and no memory write happens until the next reset.
- R9: `retired_cnt` rises by one at the end of each completed non-halt instruction. `cycle_cnt` rises by one every cycle until halt, so a program of N instructions followed by halt stops with `cycle_cnt` = 5N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW | Byte address: the program counter, or the immediate during the memory stage |
| mem_we | output | 1 | Write strobe for a store |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Word read from `mem_addr` in the same cycle |
| halted | output | 1 | High once a halt instruction has been decoded |
| retired_cnt | output | CW | Number of instructions completed |
| cycle_cnt | output | CW | Number of cycles run since reset, excluding halted cycles |

## Verification
The bench builds the core with its default parameters. These are a 32-bit data width, a 16-bit address, boot address 16 and 32-bit counters. With those values, loading the all-ones word and adding 2 reaches the wrap of the 32-bit adder, and a 19-bit immediate can address the data placed above the program. The program under test is fifteen instructions long. It mixes loads, both kinds of add, an add whose destination register is also its source, an undefined opcode and stores, so that every instruction kind leaves its result in memory for comparison. The counters at the halt point give the exact 5N+2 cycle total.

// File: rtl/seq5_pkg.sv
package seq5_pkg;
  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
  } stage_e;

  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_ADD   = 4'd2;
  localparam logic [3:0] OP_ADDI  = 4'd3;
  localparam logic [3:0] OP_STORE = 4'd4;
  localparam logic [3:0] OP_HALT  = 4'd15;

  localparam int IMM_W = 19;

  typedef struct packed {
    logic [3:0]       op;
    logic [2:0]       rd;
    logic [2:0]       ra;
    logic [2:0]       rb;
    logic [IMM_W-1:0] imm;
  } instr_t;
endpackage

// File: rtl/seq5_regfile.sv
module seq5_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [RW-1:0] raddr_a,
  input  logic [RW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  // Registered reads return the stored (old) value.
  always_ff @(posedge clk) begin
    if (re) begin
      rdata_a <= regs[raddr_a];
      rdata_b <= regs[raddr_b];
    end
  end
endmodule

// File: rtl/seq5_alu.sv
module seq5_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic [DW-1:0] sum
);
  always_comb sum = op_a + op_b;
endmodule

// File: rtl/seq5_ctrl.sv
module seq5_ctrl
  import seq5_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_halt,
  output stage_e        stage,
  output logic          halted,
  output logic [CW-1:0] retired_cnt,
  output logic [CW-1:0] cycle_cnt
);
  stage_e nxt;

  always_comb begin
    unique case (stage)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = is_halt ? ST_HALT : ST_EXEC;
      ST_EXEC:   nxt = ST_MEM;
      ST_MEM:    nxt = ST_WB;
      ST_WB:     nxt = ST_FETCH;
      default:   nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage       <= ST_FETCH;
      retired_cnt <= '0;
      cycle_cnt   <= '0;
    end else begin
      stage <= nxt;
      if (stage != ST_HALT) cycle_cnt <= cycle_cnt + 1'b1;
      if (stage == ST_WB) retired_cnt <= retired_cnt + 1'b1;
    end
  end

  always_comb halted = (stage == ST_HALT);
endmodule

// File: rtl/seq5_core.sv
module seq5_core
  import seq5_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 16,
  parameter int CW   = 32,
  parameter logic [AW-1:0] BOOT = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic [CW-1:0] retired_cnt,
  output logic [CW-1:0] cycle_cnt
);
  localparam int NREG = 8;
  localparam logic [AW-1:0] STEP = AW'(4);

  stage_e        stage;
  instr_t        ir;
  logic [AW-1:0] pc;
  logic [DW-1:0] src_a, src_b, alu_b, alu_sum, alu_q, mdr;
  logic [DW-1:0] imm_ext, wb_data;
  logic          rf_we, is_arith;

  seq5_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .is_halt(ir.op == OP_HALT),
    .stage(stage), .halted(halted),
    .retired_cnt(retired_cnt), .cycle_cnt(cycle_cnt)
  );

  always_comb begin
    imm_ext  = DW'(ir.imm);
    is_arith = (ir.op == OP_ADD) || (ir.op == OP_ADDI);
    alu_b    = (ir.op == OP_ADDI) ? imm_ext : src_b;
    rf_we    = (stage == ST_WB) && (is_arith || ir.op == OP_LOAD);
    wb_data  = (ir.op == OP_LOAD) ? mdr : alu_q;
  end

  seq5_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .we(rf_we), .waddr(ir.rd), .wdata(wb_data),
    .re(stage == ST_DECODE), .raddr_a(ir.ra), .raddr_b(ir.rb),
    .rdata_a(src_a), .rdata_b(src_b)
  );

  seq5_alu #(.DW(DW)) u_alu (.op_a(src_a), .op_b(alu_b), .sum(alu_sum));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= BOOT;
      ir <= '0;
    end else begin
      if (stage == ST_FETCH) ir <= instr_t'(mem_rdata);
      if (stage == ST_WB) pc <= pc + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (stage == ST_EXEC && is_arith) alu_q <= alu_sum;
    if (stage == ST_MEM && ir.op == OP_LOAD) mdr <= mem_rdata;
  end

  always_comb begin
    mem_addr  = (stage == ST_MEM) ? AW'(ir.imm) : pc;
    mem_we    = (stage == ST_MEM) && (ir.op == OP_STORE);
    mem_wdata = src_a;
  end
endmodule

// File: rtl/seq5_chk.sv
module seq5_chk #(
  parameter int AW = 16,
  parameter int CW = 32,
  parameter logic [AW-1:0] BOOT = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          halted,
  input logic [CW-1:0] retired_cnt,
  input logic [CW-1:0] cycle_cnt
);
  AST_BOOT_ADDR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_addr == BOOT && !halted)); // R1
  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R8
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(cycle_cnt) && $stable(retired_cnt) && !mem_we)); // R8
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !halted |=> (cycle_cnt == $past(cycle_cnt) + 1'b1)); // R9
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst)
    (retired_cnt != $past(retired_cnt)) |-> (retired_cnt == $past(retired_cnt) + 1'b1)); // R9
endmodule

bind seq5_core seq5_chk #(.AW(AW), .CW(CW), .BOOT(BOOT)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
  .halted(halted), .retired_cnt(retired_cnt), .cycle_cnt(cycle_cnt)
);

// File: tb/tb_seq5_core.sv
module tb_seq5_core;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int CW = 32;

  // Expected memory after the run: {byte address, word}
  localparam logic [63:0] VEC [7] = '{
    {32'd208, 32'd17},          // R3 R4 load+load+add+store
    {32'd212, 32'd234},         // R5 R4 addi then add self
    {32'd216, 32'hFFFF_FFFF},   // data untouched
    {32'd220, 32'd1},           // R5 wrap modulo 2^32
    {32'd224, 32'd34},          // R4 destination equals source
    {32'd228, 32'd7},           // R7 undefined opcode left R0 alone
    {32'd232, 32'd0}            // R7 undefined opcode wrote no memory
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          halted;
  logic [CW-1:0] retired_cnt, cycle_cnt;
  logic [31:0]   mem [256];
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;
  logic [CW-1:0] frz_cyc, frz_ret;

  always #2 clk = ~clk;

  seq5_core #(.DW(DW), .AW(AW), .CW(CW), .BOOT(16)) dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
    .retired_cnt(retired_cnt), .cycle_cnt(cycle_cnt)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic logic [31:0] enc(input int op, rd, ra, rb, imm);
    return {op[3:0], rd[2:0], ra[2:0], rb[2:0], imm[18:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[4]  = enc(1, 0, 0, 0, 200);   // 16 load R0
    mem[5]  = enc(1, 1, 0, 0, 204);   // 20 load R1
    mem[6]  = enc(2, 3, 0, 1, 0);     // 24 R3=R0+R1
    mem[7]  = enc(4, 0, 3, 0, 208);   // 28 store R3
    mem[8]  = enc(3, 4, 3, 0, 100);   // 32 R4=R3+100
    mem[9]  = enc(2, 5, 4, 4, 0);     // 36 R5=R4+R4
    mem[10] = enc(4, 0, 5, 0, 212);   // 40 store R5
    mem[11] = enc(1, 6, 0, 0, 216);   // 44 load R6
    mem[12] = enc(3, 7, 6, 0, 2);     // 48 R7=R6+2
    mem[13] = enc(4, 0, 7, 0, 220);   // 52 store R7
    mem[14] = enc(2, 3, 3, 3, 0);     // 56 R3=R3+R3
    mem[15] = enc(4, 0, 3, 0, 224);   // 60 store R3
    mem[16] = enc(7, 0, 3, 3, 232);   // 64 undefined opcode
    mem[17] = enc(4, 0, 0, 0, 228);   // 68 store R0
    mem[18] = enc(15, 0, 0, 0, 0);    // 72 halt
    mem[50] = 32'd7;
    mem[51] = 32'd10;
    mem[54] = 32'hFFFF_FFFF;

    @(negedge clk); @(negedge clk);
    chk("R1 addr in reset", 32'(mem_addr), 32'd16);
    rst = 1'b0;
    for (int k = 0; k <= 100; k++) begin
      if (k == 0) begin
        chk("R1 boot addr", 32'(mem_addr), 32'd16);
        chk("R1 we", 32'(mem_we), 0);
        chk("R1 halted", 32'(halted), 0);
        chk("R1 cycles", cycle_cnt, 0);
        chk("R1 retired", retired_cnt, 0);
      end
      if (k == 5)  chk("R2 fetch instr1", 32'(mem_addr), 32'd20);
      if (k == 4)  chk("R9 retired before first WB end", retired_cnt, 0);
      if (k == 5)  chk("R9 retired after first", retired_cnt, 1);
      if (k == 60) chk("R2 fetch instr12", 32'(mem_addr), 32'd64);
      if (k == 17) chk("R6 no strobe before", 32'(mem_we), 0);
      if (k == 18) begin
        chk("R6 strobe", 32'(mem_we), 1);
        chk("R6 addr", 32'(mem_addr), 32'd208);
        chk("R6 data", mem_wdata, 32'd17);
      end
      if (k == 19) chk("R6 no strobe after", 32'(mem_we), 0);
      if (k == 63) chk("R7 undefined op no write", 32'(mem_we), 0);
      if (k == 65) chk("R7 undefined op five cycles", 32'(mem_addr), 32'd68);
      if (k == 71) chk("R8 not yet halted", 32'(halted), 0);
      if (k == 72) begin
        chk("R8 halted", 32'(halted), 1);
        chk("R9 cycles 5N+2", cycle_cnt, 32'd72);
        chk("R9 retired N", retired_cnt, 32'd14);
        frz_cyc = cycle_cnt;
        frz_ret = retired_cnt;
      end
      @(negedge clk);
    end
    chk("R8 frozen cycles", cycle_cnt, frz_cyc);
    chk("R8 frozen retired", retired_cnt, frz_ret);
    chk("R8 still halted", 32'(halted), 1);

    for (int v = 0; v < 7; v++)
      chk("R3-table memory word", mem[VEC[v][41:34]], VEC[v][31:0]);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 re-reset halted", 32'(halted), 0);
    chk("R1 re-reset cycles", cycle_cnt, 0);
    chk("R1 re-reset addr", 32'(mem_addr), 32'd16);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule